// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block turns a three-wire serial audio stream (bit clock, word-select clock and data) into parallel stereo samples. It runs as a slave: both clocks come from outside and pass through a configurable synchroniser into the system clock domain. The block watches the bit clock for the sampling edge selected by the configuration and captures data only on that edge.

Four framings are handled: I2S, left justified, right justified, and a DSP-style framing in which a word-select pulse marks the start of each frame. Configuration inputs set the framing, the word length (16, 20, 24 or 32 bits), whether the word-select line is inverted (in DSP framing this input picks the A or B variant), and which bit-clock edge is used. Each word is converted to a 24-bit signed output. Short words are left-aligned and padded with zeros. For 32-bit words the top 24 bits are kept. Once the right word of a frame is complete, the block presents the left and right samples together with a one-cycle valid strobe.

An enable input gates the whole receiver. When it is low, the receiver drops valid and clears its alignment state. After it rises, the receiver waits for a real word-select transition before it trusts any bit count.

Top module: `aud_rx_deser`

## Requirements
- R1: After reset, `smp_vld` is low and `smp_left` and `smp_right` are zero.
- R2: While `rx_en` is 0, no valid strobe is produced. After `rx_en` rises, the first level the receiver sees on the word-select line is only stored. The receiver aligns on the first transition after that, so the frame that contains that transition yields no output.
- R3: With framing code 2'b10 (I2S), the left word goes with internal word-select low. Its MSB is taken on the second sampling edge after the word-select transition.
- R4: With framing code 2'b01 (left justified), the left word goes with internal word-select high. Its MSB is taken on the first sampling edge after the transition.
- R5: With framing code 2'b00 (right justified), left goes with internal word-select high. The word is the last N bits sampled before the word-select transition that ends its half, where N is the effective word length.
- R6: With framing code 2'b11 (DSP), a rising edge on the word-select input starts a frame, and the polarity input does not invert the line. Polarity 0 (variant A) puts the left MSB on the second sampling edge after that rise. Polarity 1 (variant B) puts it on the first. The right word follows the left word's LSB immediately.
- R7: Word length code 2'b00 (16 bits) yields the word in bits 23:8 with 8 zero LSBs. Code 2'b01 (20 bits) yields it in bits 23:4 with 4 zero LSBs. Code 2'b10 (24 bits) is passed through unchanged.
- R8: Word length code 2'b11 (32 bits) keeps the 24 most significant received bits and drops the lowest 8.
- R9: With right justified framing, word length code 2'b11 is treated as 24 bits.
- R10: In the I2S, left justified and right justified framings, polarity input 1 inverts the word-select line before the channel is decoded.
- R11: Bit-clock polarity 0 samples on rising bit-clock edges. Polarity 1 samples on falling edges.
- R12: `smp_vld` is a single-cycle pulse, one per frame. `smp_left` and `smp_right` change only in a cycle where `smp_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_fmt | input | 2 | Framing: 00 right just., 01 left just., 10 I2S, 11 DSP |
| cfg_wl | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| cfg_lrp | input | 1 | Word-select inversion, or DSP variant select |
| cfg_bcp | input | 1 | Bit-clock polarity (sampling edge) |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External word-select clock |
| sdata_i | input | 1 | Serial data |
| smp_left | output | 24 | Left sample, signed, left-aligned |
| smp_right | output | 24 | Right sample, signed, left-aligned |
| smp_vld | output | 1 | One-cycle strobe for a new stereo pair |

## Verification
The bench serialises a series of frames in which the left and right words differ and every frame carries different values. It then compares each output pair with the zero-padded or truncated form of the words it sent, so a channel swap, a bit slip of one position or a wrong padding amount each produces a mismatch. Each framing is run with at least one word length. One right-justified run uses the 32-bit code and sends only 24 bits, which separates the 24-bit fallback from real 32-bit truncation. Separate runs flip the word-select and bit-clock polarities, and the DSP runs cover both variants, so an off-by-one in edge choice or start delay shows up. A stream sent with the receiver disabled, together with the exact count of strobes after enable, shows that nothing leaks out before the receiver is aligned.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_DSP = 2'b11
   } fmt_e;

   typedef enum logic [1:0] {
      WL_16 = 2'b00,
      WL_20 = 2'b01,
      WL_24 = 2'b10,
      WL_32 = 2'b11
   } wl_e;

   // Effective word length; 32 bits collapses to 24 in right-justified framing
   function automatic logic [5:0] eff_bits(input wl_e wl, input fmt_e fmt);
      case (wl)
         WL_16:   return 6'd16;
         WL_20:   return 6'd20;
         WL_24:   return 6'd24;
         default: return (fmt == FMT_RJ) ? 6'd24 : 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrclk_i,
   input  logic sdata_i,
   input  logic bcp,
   output logic bit_stb,
   output logic lr_s,
   output logic sd_s
);

   logic       bclk_s;
   logic       bclk_d;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign {bclk_s, lr_s, sd_s} = {bclk_i, lrclk_i, sdata_i};
      end else begin : g_sync
         logic [2:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= {bclk_i, lrclk_i, sdata_i};
               for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign {bclk_s, lr_s, sd_s} = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= bclk_s;
   end

   // R11: polarity picks rising (0) or falling (1) as the sampling edge
   assign bit_stb = bcp ? (bclk_d & ~bclk_s) : (~bclk_d & bclk_s);

endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
   import aud_rx_pkg::*;
#(
   parameter int MAX_WL = 32,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  fmt_e              fmt,
   input  logic [5:0]        nbits,
   input  logic              lrp,
   input  logic              bit_stb,
   input  logic              lr_s,
   input  logic              sd_s,
   output logic              cap_stb,
   output logic              cap_right,
   output logic [MAX_WL-1:0] cap_word
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              primed_q, synced_q, lr_prev_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [MAX_WL-1:0] shreg_q;

   logic              lr_i, dly, trans, live;
   logic [CNT_W-1:0]  k_now, n_c, d_c, end_a, end_b;
   logic [MAX_WL-1:0] shifted;

   always_comb begin
      lr_i    = (fmt == FMT_DSP) ? lr_s : (lr_s ^ lrp);
      dly     = (fmt == FMT_I2S) || ((fmt == FMT_DSP) && !lrp);
      trans   = primed_q && ((fmt == FMT_DSP) ? (lr_i && !lr_prev_q)
                                              : (lr_i != lr_prev_q));
      k_now   = trans ? '0 : cnt_q;
      live    = synced_q || trans;
      n_c     = CNT_W'(nbits);
      d_c     = CNT_W'(dly);
      end_a   = n_c - CNT_W'(1) + d_c;
      end_b   = n_c + n_c - CNT_W'(1) + d_c;
      shifted = {shreg_q[MAX_WL-2:0], sd_s};

      cap_stb   = 1'b0;
      cap_right = 1'b0;
      cap_word  = shifted;
      if (bit_stb && en) begin
         case (fmt)
            FMT_RJ: if (trans && synced_q) begin
               cap_stb   = 1'b1;
               cap_right = !lr_prev_q;
               cap_word  = shreg_q;
            end
            FMT_LJ: if (live && k_now == end_a) begin
               cap_stb   = 1'b1;
               cap_right = !lr_i;
            end
            FMT_I2S: if (live && k_now == end_a) begin
               cap_stb   = 1'b1;
               cap_right = lr_i;
            end
            default: if (live && k_now == end_a) begin
               cap_stb   = 1'b1;
            end else if (live && k_now == end_b) begin
               cap_stb   = 1'b1;
               cap_right = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         primed_q  <= 1'b0;
         synced_q  <= 1'b0;
         lr_prev_q <= 1'b0;
         cnt_q     <= '0;
         shreg_q   <= '0;
      end else if (!en) begin
         primed_q  <= 1'b0;
         synced_q  <= 1'b0;
         lr_prev_q <= 1'b0;
         cnt_q     <= '0;
         shreg_q   <= '0;
      end else if (bit_stb) begin
         primed_q  <= 1'b1;
         lr_prev_q <= lr_i;
         shreg_q   <= shifted;
         cnt_q     <= (k_now == CNT_MAX) ? CNT_MAX : k_now + CNT_W'(1);
         if (trans) synced_q <= 1'b1;
      end
   end

   // R2: a disabled receiver forgets its alignment
   a_r2_align_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0 && !synced_q && !primed_q));

endmodule

// File: rtl/aud_rx_norm.sv
module aud_rx_norm #(
   parameter int MAX_WL = 32,
   parameter int OUT_W  = 24
) (
   input  logic [MAX_WL-1:0] word,
   input  logic [5:0]        nbits,
   output logic [OUT_W-1:0]  smp
);

   logic [MAX_WL-1:0] masked;
   logic [OUT_W-1:0]  pad_mask;

   always_comb begin
      masked = word & ~({MAX_WL{1'b1}} << nbits);
      if (int'(nbits) >= OUT_W) smp = OUT_W'(masked >> (int'(nbits) - OUT_W));
      else                      smp = OUT_W'(masked << (OUT_W - int'(nbits)));
      pad_mask = '0;
      if (int'(nbits) < OUT_W) pad_mask = ~({OUT_W{1'b1}} << (OUT_W - int'(nbits)));
   end

   // R7: short words leave zeros in the unused low bits
   always_comb begin
      if (int'(nbits) < OUT_W)
         a_r7_pad_zero: assert ((smp & pad_mask) == '0);
   end

endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
   import aud_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MAX_WL      = 32,
   parameter int OUT_W       = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_en,
   input  logic [1:0]       cfg_fmt,
   input  logic [1:0]       cfg_wl,
   input  logic             cfg_lrp,
   input  logic             cfg_bcp,
   input  logic             bclk_i,
   input  logic             lrclk_i,
   input  logic             sdata_i,
   output logic [OUT_W-1:0] smp_left,
   output logic [OUT_W-1:0] smp_right,
   output logic             smp_vld
);

   localparam int CNT_W = $clog2(2 * MAX_WL + 2);

   generate
      if (MAX_WL < 32) begin : g_bad_wl
         $error("MAX_WL must cover 32-bit words");
      end
      if (OUT_W > MAX_WL || OUT_W < 16) begin : g_bad_out
         $error("OUT_W must lie between 16 and MAX_WL");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   fmt_e              fmt;
   logic [5:0]        nbits;
   logic              bit_stb, lr_s, sd_s;
   logic              cap_stb, cap_right;
   logic [MAX_WL-1:0] cap_word;
   logic [OUT_W-1:0]  cap_smp, left_hold;
   logic              left_ok;

   assign fmt   = fmt_e'(cfg_fmt);
   assign nbits = eff_bits(wl_e'(cfg_wl), fmt);

   aud_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .lrclk_i (lrclk_i),
      .sdata_i (sdata_i),
      .bcp     (cfg_bcp),
      .bit_stb (bit_stb),
      .lr_s    (lr_s),
      .sd_s    (sd_s)
   );

   aud_rx_frame #(.MAX_WL(MAX_WL), .CNT_W(CNT_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (rx_en),
      .fmt       (fmt),
      .nbits     (nbits),
      .lrp       (cfg_lrp),
      .bit_stb   (bit_stb),
      .lr_s      (lr_s),
      .sd_s      (sd_s),
      .cap_stb   (cap_stb),
      .cap_right (cap_right),
      .cap_word  (cap_word)
   );

   aud_rx_norm #(.MAX_WL(MAX_WL), .OUT_W(OUT_W)) u_norm (
      .word  (cap_word),
      .nbits (nbits),
      .smp   (cap_smp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_left  <= '0;
         smp_right <= '0;
         smp_vld   <= 1'b0;
         left_hold <= '0;
         left_ok   <= 1'b0;
      end else if (!rx_en) begin
         smp_vld   <= 1'b0;
         left_ok   <= 1'b0;
      end else begin
         smp_vld <= 1'b0;
         if (cap_stb && !cap_right) begin
            left_hold <= cap_smp;
            left_ok   <= 1'b1;
         end else if (cap_stb && left_ok) begin
            smp_left  <= left_hold;
            smp_right <= cap_smp;
            smp_vld   <= 1'b1;
         end
      end
   end

   // R12: strobe lasts one cycle
   a_r12_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> !smp_vld);

   // R12: samples move only together with the strobe
   a_r12_hold_samples: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |-> ($stable(smp_left) && $stable(smp_right)));

   // R2: disabled receiver produces no strobe
   a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !smp_vld);

endmodule

// File: tb/aud_rx_deser_tb.sv
module aud_rx_deser_tb;

   localparam int H = 34;   // bit slots per half frame
   localparam int F = 4;    // frames per run (plus one trailing)

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b0;
   logic [1:0]  cfg_fmt = 2'b10, cfg_wl = 2'b10;
   logic        cfg_lrp = 1'b0, cfg_bcp = 1'b0;
   logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
   logic [23:0] smp_left, smp_right;
   logic        smp_vld;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [23:0] got_l [16];
   logic [23:0] got_r [16];
   int got_n = 0;

   always #4 clk = ~clk;

   aud_rx_deser u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_fmt(cfg_fmt), .cfg_wl(cfg_wl),
      .cfg_lrp(cfg_lrp), .cfg_bcp(cfg_bcp), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
      .sdata_i(sdata_i), .smp_left(smp_left), .smp_right(smp_right), .smp_vld(smp_vld)
   );

   always @(negedge clk) begin
      if (smp_vld) begin
         if (got_n < 16) begin
            got_l[got_n] = smp_left;
            got_r[got_n] = smp_right;
         end
         got_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input int f, input bit ch);
      return (32'h9E3779B9 * (f + 3)) ^ (ch ? 32'hC3A55A3C : 32'h0);
   endfunction

   function automatic int eff_n();
      case (cfg_wl)
         2'b00:   return 16;
         2'b01:   return 20;
         2'b10:   return 24;
         default: return (cfg_fmt == 2'b00) ? 24 : 32;
      endcase
   endfunction

   function automatic logic [23:0] exp24(input logic [31:0] w, input int n);
      case (n)
         16:      return {w[15:0], 8'h00};
         20:      return {w[19:0], 4'h0};
         24:      return w[23:0];
         default: return w[31:8];
      endcase
   endfunction

   function automatic logic lr_pin(input int s);
      logic lv;
      if (cfg_fmt == 2'b11) return (s == 0);
      lv = (cfg_fmt == 2'b10) ? 1'b0 : 1'b1;
      return ((s < H) ? lv : ~lv) ^ cfg_lrp;
   endfunction

   function automatic logic data_bit(input int f, input int s);
      int n = eff_n();
      logic [31:0] w;
      int k, j, d;
      if (cfg_fmt == 2'b11) begin
         d = cfg_lrp ? 0 : 1;
         j = s - d;
         if (j >= 0 && j < n) return word(f, 0)[n-1-j];
         if (j >= n && j < 2*n) return word(f, 1)[2*n-1-j];
         return 1'b0;
      end
      w = (s < H) ? word(f, 0) : word(f, 1);
      k = s % H;
      case (cfg_fmt)
         2'b01:   return (k < n) ? w[n-1-k] : 1'b0;
         2'b10:   return (k >= 1 && k <= n) ? w[n-k] : 1'b0;
         default: return (k >= H - n) ? w[H-1-k] : 1'b0;
      endcase
   endfunction

   task automatic stream(input int frames);
      for (int f = 0; f < frames; f++) begin
         for (int s = 0; s < 2*H; s++) begin
            bclk_i  = cfg_bcp;
            lrclk_i = lr_pin(s);
            sdata_i = data_bit(f, s);
            repeat (4) @(negedge clk);
            bclk_i  = ~cfg_bcp;
            repeat (4) @(negedge clk);
         end
      end
   endtask

   task automatic run_case(input string req, input logic [1:0] fmt, input logic [1:0] wl,
                           input logic lrp, input logic bcp);
      int n, exp_cnt;
      rx_en = 1'b0;
      cfg_fmt = fmt; cfg_wl = wl; cfg_lrp = lrp; cfg_bcp = bcp;
      bclk_i = bcp;
      repeat (10) @(negedge clk);
      got_n = 0;
      rx_en = 1'b1;
      stream(F + 1);
      repeat (20) @(negedge clk);
      rx_en = 1'b0;
      n = eff_n();
      exp_cnt = (fmt == 2'b00) ? F - 1 : F;
      // R2 and R12: first frame dropped for alignment, one strobe per frame after it
      chk(got_n == exp_cnt, {req, " R2 R12 strobe count"}, got_n, exp_cnt);
      for (int i = 0; i < F - 1; i++) begin
         chk(got_l[i] === exp24(word(i + 1, 0), n), {req, " left"}, got_l[i], exp24(word(i + 1, 0), n));
         chk(got_r[i] === exp24(word(i + 1, 1), n), {req, " right"}, got_r[i], exp24(word(i + 1, 1), n));
      end
   endtask

   task automatic test_reset();
      chk(smp_vld == 1'b0, "R1 valid after reset", smp_vld, 0);
      chk(smp_left == '0 && smp_right == '0, "R1 samples after reset", {smp_left[15:0], smp_right[15:0]}, 0);
   endtask

   task automatic test_disabled();
      rx_en = 1'b0;
      cfg_fmt = 2'b01; cfg_wl = 2'b10; cfg_lrp = 1'b0; cfg_bcp = 1'b0;
      got_n = 0;
      stream(3);
      repeat (20) @(negedge clk);
      chk(got_n == 0, "R2 no strobe while disabled", got_n, 0);
   endtask

   task automatic test_i2s_24();  run_case("R3 R7 I2S 24-bit", 2'b10, 2'b10, 1'b0, 1'b0); endtask
   task automatic test_lj_24();   run_case("R4 LJ 24-bit",     2'b01, 2'b10, 1'b0, 1'b0); endtask
   task automatic test_rj_16();   run_case("R5 R7 RJ 16-bit",  2'b00, 2'b00, 1'b0, 1'b0); endtask
   task automatic test_lj_20();   run_case("R7 LJ 20-bit",     2'b01, 2'b01, 1'b0, 1'b0); endtask
   task automatic test_i2s_32();  run_case("R8 I2S 32-bit",    2'b10, 2'b11, 1'b0, 1'b0); endtask
   task automatic test_rj_32();   run_case("R9 RJ 32 as 24",   2'b00, 2'b11, 1'b0, 1'b0); endtask
   task automatic test_dsp_a();   run_case("R6 DSP A 24-bit",  2'b11, 2'b10, 1'b0, 1'b0); endtask
   task automatic test_dsp_b();   run_case("R6 DSP B 16-bit",  2'b11, 2'b00, 1'b1, 1'b0); endtask
   task automatic test_i2s_inv(); run_case("R10 I2S inverted", 2'b10, 2'b10, 1'b1, 1'b0); endtask
   task automatic test_rj_inv();  run_case("R10 RJ inverted",  2'b00, 2'b01, 1'b1, 1'b0); endtask
   task automatic test_lj_fall(); run_case("R11 LJ falling",   2'b01, 2'b10, 1'b0, 1'b1); endtask
   task automatic test_dsp_fall(); run_case("R11 R6 DSP A 32 falling", 2'b11, 2'b11, 1'b0, 1'b1); endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      test_disabled();
      test_i2s_24();
      test_lj_24();
      test_rj_16();
      test_lj_20();
      test_i2s_32();
      test_rj_32();
      test_dsp_a();
      test_dsp_b();
      test_i2s_inv();
      test_rj_inv();
      test_lj_fall();
      test_dsp_fall();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule